// File: doc/BRIEF.md
# Split Dual 8-bit Auto-Reload Timer

This block is a timer peripheral made of two independent 8-bit up-counters, a low half and a high half. Each half has its own reload register. When a half rolls over from its all-ones value, it loads that register instead of going to zero, so it produces a periodic overflow. Each half picks its own count rate. It can count on every system clock, on a system clock divided by twelve, or on an external clock divided by eight. The external clock input is asynchronous. The block synchronizes it and counts its rising edges inside the system clock domain.

Each half sets a sticky overflow flag when it rolls over. Only a software clear strobe resets a flag. One combined interrupt request is a level: the enabled flags are ORed and then gated by a global enable. The high-half flag always reaches the request. The low-half flag reaches it only when its own enable bit is set. The high half counts only while its run bit is set. The low half counts whenever split operation is active. Split operation is active only when the split bit is set and the capture-enable bit is clear. In any other combination both halves hold their values.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset both counts are 0x00, both reload registers are 0x00, both flags are 0 and `irq` is 0.
- R2: Split operation is active only when `splitMode` is 1 and `captureEn` is 0. Otherwise neither count changes.
- R3: While split operation is active the low half counts regardless of `runHi`. The high half counts only while `runHi` is 1 and holds its value while `runHi` is 0.
- R4: When a half's clock-mode bit (`loClkFast` or `hiClkFast`) is 1, that half advances by one on every system clock cycle.
- R5: When a half's clock-mode bit is 0 and `extSel` is 0, that half advances exactly once every 12 system clock cycles.
- R6: When a half's clock-mode bit is 0 and `extSel` is 1, that half advances once per 8 rising edges of `extClk`. With `extClk` still, it holds.
- R7: An advance from 0xFF loads the half's own reload value: the low half loads the value written with `reloadLoWr`, and the high half loads the value written with `reloadHiWr`. A reload write takes effect from the next cycle.
- R8: A rollover of a half sets its flag (`flagLo` or `flagHi`) at the same clock edge. A flag stays set until its clear strobe (`flagLoClr` or `flagHiClr`) is high at a clock edge.
- R9: If a clear strobe and a rollover of the same half fall on the same clock edge, the flag ends up set.
- R10: `irq` equals `irqEn AND (flagHi OR (loIrqEn AND flagLo))`, as a level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extClk | input | 1 | Asynchronous external clock |
| splitMode | input | 1 | Selects split dual-8-bit operation |
| captureEn | input | 1 | Capture enable; split operation needs it at 0 |
| runHi | input | 1 | Run control for the high half |
| loClkFast | input | 1 | Low half counts on every system clock when 1 |
| hiClkFast | input | 1 | High half counts on every system clock when 1 |
| extSel | input | 1 | Slow tick source: 0 = system clock/12, 1 = external clock/8 |
| irqEn | input | 1 | Global timer interrupt enable |
| loIrqEn | input | 1 | Lets the low flag raise the interrupt |
| reloadLoWr | input | 1 | Write strobe for the low reload register |
| reloadHiWr | input | 1 | Write strobe for the high reload register |
| reloadData | input | 8 | Reload write data |
| flagLoClr | input | 1 | Clear strobe for the low flag |
| flagHiClr | input | 1 | Clear strobe for the high flag |
| cntLo | output | 8 | Low half count |
| cntHi | output | 8 | High half count |
| flagLo | output | 1 | Low half overflow flag |
| flagHi | output | 1 | High half overflow flag |
| irq | output | 1 | Combined interrupt request (level) |

## Verification
The assertions check the following on every cycle:
- Both counts hold while split operation is inactive.
- The high count holds while stopped.
- The low count steps by one in fast mode.
- A fast-mode rollover sets the flag, and the flags are sticky.
- The interrupt request agrees with the flags and enables.

Only the bench scenarios can show the following:
- The exact prescaler periods (12 cycles, and 8 external edges).
- That each half loads its own reload value, including reloads of 0xFF and 0xFE.
- That a clear which meets a rollover on the same edge loses.

The bench compares a cycle-level model against the ports while it sweeps the reload values and all four interrupt-enable combinations.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int HALF_LO    = 0;
  localparam int HALF_HI    = 1;
  localparam int NUM_HALVES = 2;

  // Strobes from control to datapath, one bit per half
  typedef struct packed {
    logic [NUM_HALVES-1:0] inc;      // advance this half on this edge
    logic [NUM_HALVES-1:0] loadRel;  // capture reloadData into this half's reload register
  } drtStrobes_t;
endpackage

// File: rtl/drt_prescaler.sv
module drt_prescaler #(
  parameter int SYS_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic extClk,
  output logic sysTick,
  output logic extTick
);
  localparam int SYS_CW = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
  localparam int EXT_CW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;
  localparam logic [SYS_CW-1:0] SYS_LAST = SYS_CW'(SYS_DIV - 1);
  localparam logic [EXT_CW-1:0] EXT_LAST = EXT_CW'(EXT_DIV - 1);

  // Free-running system clock divider; one-cycle pulse on its last count
  logic [SYS_CW-1:0] sysCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sysCnt <= '0;
    else if (sysCnt == SYS_LAST) sysCnt <= '0;
    else                         sysCnt <= sysCnt + SYS_CW'(1);
  end
  assign sysTick = (sysCnt == SYS_LAST);

  // External clock: synchronizer chain, then rising-edge detect
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   extPrev;
  logic                   extRise;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      extPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extClk};
      extPrev <= syncQ[SYNC_STAGES-1];
    end
  end
  assign extRise = syncQ[SYNC_STAGES-1] & ~extPrev;

  // Divide the rising edges
  logic [EXT_CW-1:0] extCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extCnt <= '0;
    else if (extRise) begin
      if (extCnt == EXT_LAST) extCnt <= '0;
      else                    extCnt <= extCnt + EXT_CW'(1);
    end
  end
  assign extTick = extRise && (extCnt == EXT_LAST);
endmodule

// File: rtl/drt_control.sv
module drt_control
  import drt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  splitMode,
  input  logic                  captureEn,
  input  logic                  runHi,
  input  logic                  loClkFast,
  input  logic                  hiClkFast,
  input  logic                  extSel,
  input  logic                  irqEn,
  input  logic                  loIrqEn,
  input  logic                  reloadLoWr,
  input  logic                  reloadHiWr,
  input  logic                  flagLoClr,
  input  logic                  flagHiClr,
  input  logic                  sysTick,
  input  logic                  extTick,
  input  logic [NUM_HALVES-1:0] wrap,
  output drtStrobes_t           strobes,
  output logic                  flagLo,
  output logic                  flagHi,
  output logic                  irq
);
  logic                  splitActive;
  logic                  slowTick;
  logic [NUM_HALVES-1:0] clkFast;
  logic [NUM_HALVES-1:0] runEn;
  logic [NUM_HALVES-1:0] clrReq;
  logic [NUM_HALVES-1:0] incVec;
  logic [NUM_HALVES-1:0] flagQ;

  assign splitActive = splitMode & ~captureEn;
  assign slowTick    = extSel ? extTick : sysTick;

  always_comb begin
    clkFast          = '0;
    runEn            = '0;
    clrReq           = '0;
    clkFast[HALF_LO] = loClkFast;
    clkFast[HALF_HI] = hiClkFast;
    runEn[HALF_LO]   = 1'b1;   // the low half has no run gate
    runEn[HALF_HI]   = runHi;
    clrReq[HALF_LO]  = flagLoClr;
    clrReq[HALF_HI]  = flagHiClr;
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    assign incVec[h] = splitActive & runEn[h] & (clkFast[h] | slowTick);

    // Setting wins over clearing on the same edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ[h] <= 1'b0;
      else       flagQ[h] <= wrap[h] | (flagQ[h] & ~clrReq[h]);
    end
  end

  always_comb begin
    strobes                  = '0;
    strobes.inc              = incVec;
    strobes.loadRel[HALF_LO] = reloadLoWr;
    strobes.loadRel[HALF_HI] = reloadHiWr;
  end

  assign flagLo = flagQ[HALF_LO];
  assign flagHi = flagQ[HALF_HI];
  assign irq    = irqEn & (flagQ[HALF_HI] | (loIrqEn & flagQ[HALF_LO]));
endmodule

// File: rtl/drt_datapath.sv
module drt_datapath
  import drt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  drtStrobes_t           strobes,
  input  logic [WIDTH-1:0]      reloadData,
  output logic [WIDTH-1:0]      cntLo,
  output logic [WIDTH-1:0]      cntHi,
  output logic [NUM_HALVES-1:0] wrap
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  logic [WIDTH-1:0] cntQ [NUM_HALVES];
  logic [WIDTH-1:0] relQ [NUM_HALVES];

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    assign wrap[h] = strobes.inc[h] && (cntQ[h] == CNT_MAX);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  relQ[h] <= '0;
      else if (strobes.loadRel[h]) relQ[h] <= reloadData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                cntQ[h] <= '0;
      else if (strobes.inc[h]) cntQ[h] <= wrap[h] ? relQ[h] : cntQ[h] + WIDTH'(1);
    end
  end

  assign cntLo = cntQ[HALF_LO];
  assign cntHi = cntQ[HALF_HI];
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import drt_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYS_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extClk,
  input  logic             splitMode,
  input  logic             captureEn,
  input  logic             runHi,
  input  logic             loClkFast,
  input  logic             hiClkFast,
  input  logic             extSel,
  input  logic             irqEn,
  input  logic             loIrqEn,
  input  logic             reloadLoWr,
  input  logic             reloadHiWr,
  input  logic [WIDTH-1:0] reloadData,
  input  logic             flagLoClr,
  input  logic             flagHiClr,
  output logic [WIDTH-1:0] cntLo,
  output logic [WIDTH-1:0] cntHi,
  output logic             flagLo,
  output logic             flagHi,
  output logic             irq
);
  logic                  sysTick;
  logic                  extTick;
  logic [NUM_HALVES-1:0] wrap;
  drtStrobes_t           strobes;

  drt_prescaler #(
    .SYS_DIV    (SYS_DIV),
    .EXT_DIV    (EXT_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) prescale_i (
    .clk    (clk),
    .rstN   (rstN),
    .extClk (extClk),
    .sysTick(sysTick),
    .extTick(extTick)
  );

  drt_control control_i (
    .clk       (clk),
    .rstN      (rstN),
    .splitMode (splitMode),
    .captureEn (captureEn),
    .runHi     (runHi),
    .loClkFast (loClkFast),
    .hiClkFast (hiClkFast),
    .extSel    (extSel),
    .irqEn     (irqEn),
    .loIrqEn   (loIrqEn),
    .reloadLoWr(reloadLoWr),
    .reloadHiWr(reloadHiWr),
    .flagLoClr (flagLoClr),
    .flagHiClr (flagHiClr),
    .sysTick   (sysTick),
    .extTick   (extTick),
    .wrap      (wrap),
    .strobes   (strobes),
    .flagLo    (flagLo),
    .flagHi    (flagHi),
    .irq       (irq)
  );

  drt_datapath #(
    .WIDTH(WIDTH)
  ) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reloadData(reloadData),
    .cntLo     (cntLo),
    .cntHi     (cntHi),
    .wrap      (wrap)
  );
endmodule

// File: rtl/dual_reload_timer_chk.sv
module dual_reload_timer_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             splitMode,
  input logic             captureEn,
  input logic             runHi,
  input logic             loClkFast,
  input logic             irqEn,
  input logic             loIrqEn,
  input logic             flagLoClr,
  input logic             flagHiClr,
  input logic [WIDTH-1:0] cntLo,
  input logic [WIDTH-1:0] cntHi,
  input logic             flagLo,
  input logic             flagHi,
  input logic             irq
);
  logic activeNow;
  assign activeNow = splitMode && !captureEn;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (cntLo == '0 && cntHi == '0 && !flagLo && !flagHi && !irq)); // R1

  AST_HOLD_INACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    !activeNow |=> ($stable(cntLo) && $stable(cntHi))); // R2

  AST_HI_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !runHi |=> $stable(cntHi)); // R3

  AST_FAST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (activeNow && loClkFast && cntLo != '1) |=> (cntLo == $past(cntLo) + WIDTH'(1))); // R4

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (activeNow && loClkFast && cntLo == '1) |=> flagLo); // R8

  AST_FLAG_LO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagLo && !flagLoClr) |=> flagLo); // R8

  AST_FLAG_HI_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagHi && !flagHiClr) |=> flagHi); // R8

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (irqEn && (flagHi || flagLo))); // R10

  AST_IRQ_LO_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !loIrqEn) |-> flagHi); // R10

  AST_IRQ_HI_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn && flagHi) |-> irq); // R10
endmodule

bind dual_reload_timer dual_reload_timer_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .splitMode(splitMode),
  .captureEn(captureEn),
  .runHi    (runHi),
  .loClkFast(loClkFast),
  .irqEn    (irqEn),
  .loIrqEn  (loIrqEn),
  .flagLoClr(flagLoClr),
  .flagHiClr(flagHiClr),
  .cntLo    (cntLo),
  .cntHi    (cntHi),
  .flagLo   (flagLo),
  .flagHi   (flagHi),
  .irq      (irq)
);

// File: tb/dual_reload_timer_tb_top.sv
module dual_reload_timer_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic extClk = 1'b0;
  logic extRun = 1'b0;
  logic splitMode = 0, captureEn = 0, runHi = 0, loClkFast = 1, hiClkFast = 1, extSel = 0;
  logic irqEn = 0, loIrqEn = 0, reloadLoWr = 0, reloadHiWr = 0, flagLoClr = 0, flagHiClr = 0;
  logic [W-1:0] reloadData = '0;
  logic [W-1:0] cntLo, cntHi;
  logic flagLo, flagHi, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // External clock: period 32 ns (4 system cycles) while running
  always begin
    #16;
    if (extRun) extClk = ~extClk;
  end

  dual_reload_timer dut_i (
    .clk(clk), .rstN(rstN), .extClk(extClk), .splitMode(splitMode), .captureEn(captureEn),
    .runHi(runHi), .loClkFast(loClkFast), .hiClkFast(hiClkFast), .extSel(extSel),
    .irqEn(irqEn), .loIrqEn(loIrqEn), .reloadLoWr(reloadLoWr), .reloadHiWr(reloadHiWr),
    .reloadData(reloadData), .flagLoClr(flagLoClr), .flagHiClr(flagHiClr),
    .cntLo(cntLo), .cntHi(cntHi), .flagLo(flagLo), .flagHi(flagHi), .irq(irq)
  );

  // Cycle model, valid while both clock-mode bits are 1
  logic [W-1:0] mLo, mHi, mRelLo, mRelHi;
  logic mFLo, mFHi;
  always @(posedge clk) begin
    logic act, incLo, incHi, wLo, wHi;
    if (!rstN) begin
      mLo <= '0; mHi <= '0; mRelLo <= '0; mRelHi <= '0; mFLo <= 0; mFHi <= 0;
    end else begin
      act   = splitMode && !captureEn;
      incLo = act && loClkFast;
      incHi = act && runHi && hiClkFast;
      wLo   = incLo && (mLo == 8'hFF);
      wHi   = incHi && (mHi == 8'hFF);
      if (incLo) mLo <= wLo ? mRelLo : mLo + 8'd1;
      if (incHi) mHi <= wHi ? mRelHi : mHi + 8'd1;
      mFLo <= wLo | (mFLo & ~flagLoClr);
      mFHi <= wHi | (mFHi & ~flagHiClr);
      if (reloadLoWr) mRelLo <= reloadData;
      if (reloadHiWr) mRelHi <= reloadData;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkModel(input string phase);
    logic expIrq;
    expIrq = irqEn && (mFHi || (loIrqEn && mFLo));
    check(cntLo == mLo, {phase, " R4 R7 cntLo"}, cntLo, mLo);
    check(cntHi == mHi, {phase, " R3 R7 cntHi"}, cntHi, mHi);
    check(flagLo == mFLo, {phase, " R8 R9 flagLo"}, flagLo, mFLo);
    check(flagHi == mFHi, {phase, " R8 flagHi"}, flagHi, mFHi);
    check(irq == expIrq, {phase, " R10 irq"}, irq, expIrq);
  endtask

  task automatic runModel(input int n, input string phase);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkModel(phase);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeReloads(input logic [W-1:0] lo, input logic [W-1:0] hi);
    @(negedge clk); reloadData = lo; reloadLoWr = 1;
    @(negedge clk); reloadLoWr = 0; reloadData = hi; reloadHiWr = 1;
    @(negedge clk); reloadHiWr = 0;
  endtask

  task automatic pulseClears();
    @(negedge clk); flagLoClr = 1; flagHiClr = 1;
    @(negedge clk); flagLoClr = 0; flagHiClr = 0;
  endtask

  // Cycles between two successive changes of a count
  task automatic measure(input bit hi, input int expGap, input string tag);
    logic [W-1:0] prev;
    int gap;
    @(negedge clk);
    prev = hi ? cntHi : cntLo;
    gap = 0;
    while ((hi ? cntHi : cntLo) == prev && gap < 400) begin @(negedge clk); gap++; end
    prev = hi ? cntHi : cntLo;
    gap = 0;
    do begin @(negedge clk); gap++; end while ((hi ? cntHi : cntLo) == prev && gap < 400);
    check(gap == expGap, tag, gap, expGap);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] relList [4];
    relList = '{8'hFF, 8'hFE, 8'hC0, 8'h00};

    // R1: reset state
    repeat (3) @(negedge clk);
    check(cntLo == 0, "R1 cntLo", cntLo, 0);
    check(cntHi == 0, "R1 cntHi", cntHi, 0);
    check(!flagLo && !flagHi, "R1 flags", {flagHi, flagLo}, 0);
    check(!irq, "R1 irq", irq, 0);
    rstN = 1'b1;

    // R2: inactive combinations hold both halves
    runHi = 1; irqEn = 1; loIrqEn = 1;
    runModel(40, "R2 split=0");
    check(cntLo == 0 && cntHi == 0, "R2 hold split=0", cntLo, 0);
    @(negedge clk); splitMode = 1; captureEn = 1;
    runModel(40, "R2 capture=1");
    check(cntLo == 0 && cntHi == 0, "R2 hold capture=1", cntLo, 0);

    // R3: low half runs, high half stopped
    @(negedge clk); captureEn = 0; runHi = 0;
    runModel(300, "R3 runHi=0");
    check(cntHi == 0, "R3 high held", cntHi, 0);

    // R7, R8, R10: sweep reloads and interrupt-enable combinations
    foreach (relList[k]) begin
      writeReloads(relList[k], ~relList[k]);
      @(negedge clk); runHi = 1;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk); {irqEn, loIrqEn} = c[1:0];
        pulseClears();
        runModel(120, "R7 R10 sweep");
      end
    end

    // R9: clear meets a rollover on the same edge
    doReset();
    @(negedge clk); splitMode = 1; captureEn = 0; runHi = 0;
    while (mLo != 8'hFF) @(negedge clk);
    flagLoClr = 1;
    @(negedge clk); flagLoClr = 0;
    check(flagLo == 1, "R9 flag kept on clear+rollover", flagLo, 1);
    runModel(20, "R9 after");

    // R5, R6: prescaled ticks
    doReset();
    @(negedge clk); splitMode = 1; captureEn = 0; runHi = 0; loClkFast = 0; extSel = 0;
    measure(0, 12, "R5 low sysclk/12");
    measure(0, 12, "R5 low sysclk/12 again");
    @(negedge clk); runHi = 1; hiClkFast = 1;
    measure(1, 1, "R4 high fast beside slow low");
    measure(0, 12, "R5 low unaffected by high mode");
    @(negedge clk); hiClkFast = 0;
    measure(1, 12, "R5 high sysclk/12");
    @(negedge clk); extSel = 1; extRun = 1;
    measure(0, 32, "R6 low ext/8");
    measure(1, 32, "R6 high ext/8");
    measure(0, 32, "R6 low ext/8 again");
    @(negedge clk); runHi = 0;
    begin
      logic [W-1:0] h0;
      h0 = cntHi;
      repeat (100) @(negedge clk);
      check(cntHi == h0, "R3 high held on slow tick", cntHi, h0);
    end
    @(negedge clk); extRun = 0;
    repeat (10) @(negedge clk);
    begin
      logic [W-1:0] l0;
      l0 = cntLo;
      repeat (100) @(negedge clk);
      check(cntLo == l0, "R6 low holds with ext clock still", cntLo, l0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule